// File: doc/BRIEF.md
# Boot Download Sequencer

This block sits on the host side of a board. It boots a target processor that is held in reset, and it does this through the target's 16-bit host access port. After a `start` pulse it reads a small table from a local synchronous ROM and replays it onto the port as a fixed sequence of halfword writes.

The sequence has three parts. The first part is a list of configuration word writes, which set up the target's memory interface before any external memory is touched. The second part is a series of section bursts, each loaded with address auto-increment. The last part is a wake command, which releases the target core. Each 32-bit quantity goes out as two halfwords over a valid/ready handshake. A select code tells the target which of its registers receives each halfword.

The ROM is word addressed and returns data one cycle after a read is enabled. It has the following layout:

- Configuration entries start at word 0. There are `CFG_N` entries, and each takes two words: the target address, then the value.
- Section headers follow at word `2*CFG_N`. There are up to `MAX_SECT` headers, and each takes three words: the destination address, the length in 32-bit words, and the ROM word offset of the section's data.

The software that builds the image places code sections ahead of initialized-data sections.

Top module: `boot_seq_top`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `prt_valid` and `rom_en` are all low, and they stay low until `start` is seen.
- R2: Every 32-bit word leaves as two port transfers. The low half is sent first with `prt_half`=0, and the high half follows with `prt_half`=1. While `prt_valid` is high and `prt_ready` is low, `prt_sel`, `prt_half` and `prt_data` hold their values.
- R3: Each configuration entry is sent in ROM order, and each one produces six transfers:
  - control select (`prt_sel`=00) carrying 0x0001 in both halves;
  - address select (01) carrying the target address;
  - fixed-address data select (11) carrying the value.
  All configuration entries go out before any section transfer.
- R4: Section headers are walked in table order. A header whose length word is zero ends the walk. The walk also ends after `MAX_SECT` headers, and headers past the end are never used.
- R5: Each section produces the following transfers:
  - control 0x0001 in both halves;
  - address select carrying the destination address;
  - one post-increment data transfer (`prt_sel`=10) for each 32-bit word read from consecutive ROM words starting at the header's offset.
- R6: After the last section, the block sends control select with 0x0002 in both halves. `done` then pulses for exactly one cycle. `busy` is high from the cycle after `start` until `done` rises, and no port transfer is offered while `busy` is low.
- R7: A `start` pulse that arrives while `busy` is high has no effect. The transfer stream is unchanged and only one `done` pulse appears.
- R8: An image whose first header has length zero produces only the configuration transfers followed by the wake pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a boot sequence (ignored while busy) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the wake write has completed |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | 32 | ROM word address |
| rom_data | input | 32 | ROM read data, valid one cycle after `rom_en` |
| prt_valid | output | 1 | Halfword transfer offered to the target port |
| prt_ready | input | 1 | Target port accepts the offered halfword |
| prt_sel | output | 2 | Register select: 00 control, 01 address, 10 data with post-increment, 11 data fixed address |
| prt_half | output | 1 | 0 for the first (low) halfword, 1 for the second (high) |
| prt_data | output | 16 | Halfword payload |

## Verification
In a single cycle, the controller decrements a section's word count and also chooses between fetching another data word and moving on to the next header. Sections of length one make the first word also the last, which pushes these two actions into the same cycle. The bench exercises this with every section count from zero up to the table limit, under three ready patterns, including one where ready is held high so no bubble hides a mistake. A second collision is a fresh `start` arriving in the middle of a download. In both cases the bench compares the full halfword stream against one it builds arithmetically from the ROM image, and it requires exactly one `done` pulse.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'b00,
    SEL_ADDR = 2'b01,
    SEL_DINC = 2'b10,
    SEL_DFIX = 2'b11
  } port_sel_e;

  localparam logic [15:0] CTRL_ORDER = 16'h0001;
  localparam logic [15:0] CTRL_WAKE  = 16'h0002;

  typedef enum logic [4:0] {
    S_IDLE,
    S_CFG_A,
    S_CFG_V,
    S_CFG_C,
    S_HDR_D,
    S_HDR_N,
    S_HDR_O,
    S_HDR_C,
    S_CTRL,
    S_ADDR,
    S_CFG_D,
    S_DAT_R,
    S_DAT_C,
    S_DAT_S,
    S_WAKE,
    S_WAIT,
    S_FIN
  } seq_st_e;

endpackage

// File: rtl/bseq_half_tx.sv
module bseq_half_tx
  import bseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [1:0]  load_sel,
  input  logic [31:0] load_word,
  output logic        tx_busy,
  output logic        pair_done,
  output logic        prt_valid,
  input  logic        prt_ready,
  output logic [1:0]  prt_sel,
  output logic        prt_half,
  output logic [15:0] prt_data
);

  logic [15:0] hi_q;

  assign tx_busy = prt_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      prt_valid <= 1'b0;
      prt_half  <= 1'b0;
      prt_sel   <= SEL_CTRL;
      prt_data  <= '0;
      hi_q      <= '0;
      pair_done <= 1'b0;
    end else begin
      pair_done <= 1'b0;
      if (!prt_valid && load) begin
        prt_valid <= 1'b1;
        prt_half  <= 1'b0;
        prt_sel   <= load_sel;
        prt_data  <= load_word[15:0];
        hi_q      <= load_word[31:16];
      end else if (prt_valid && prt_ready) begin
        if (!prt_half) begin
          prt_half <= 1'b1;
          prt_data <= hi_q;
        end else begin
          prt_valid <= 1'b0;
          prt_half  <= 1'b0;
          pair_done <= 1'b1;
        end
      end
    end
  end

  // R2: offered halfword held while the port stalls
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    prt_valid && !prt_ready |=> prt_valid && $stable(prt_data) && $stable(prt_sel) && $stable(prt_half));

  // R2: an accepted low half is followed by the high half on the same select
  p_low_high_r2: assert property (@(posedge clk) disable iff (rst)
    prt_valid && prt_ready && !prt_half |=> prt_valid && prt_half && $stable(prt_sel));

  // R2: an accepted high half ends the pair
  p_pair_end_r2: assert property (@(posedge clk) disable iff (rst)
    prt_valid && prt_ready && prt_half |=> !prt_valid && pair_done);

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int CFG_N    = 7,
  parameter int MAX_SECT = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        rom_en,
  output logic [31:0] rom_addr,
  input  logic [31:0] rom_data,
  output logic        load,
  output logic [1:0]  load_sel,
  output logic [31:0] load_word,
  input  logic        tx_busy,
  input  logic        pair_done
);

  localparam int CW = $clog2(CFG_N + 2);
  localparam int SW = $clog2(MAX_SECT + 2);

  seq_st_e        st, nxt;
  logic [31:0]    tbl_ptr;
  logic [31:0]    src_ptr;
  logic [31:0]    dest;
  logic [31:0]    word;
  logic [31:0]    cnt;
  logic [CW-1:0]  cfg_left;
  logic [SW-1:0]  sec_left;
  logic           mode_sec;
  logic           hdr_go;
  logic           send_st;

  assign hdr_go  = (st == S_HDR_D) && (sec_left != '0);
  assign send_st = (st == S_CTRL) || (st == S_ADDR) || (st == S_CFG_D) ||
                   (st == S_DAT_S) || (st == S_WAKE);

  always_comb begin
    rom_en   = 1'b0;
    rom_addr = tbl_ptr;
    unique case (st)
      S_CFG_A, S_CFG_V, S_HDR_N, S_HDR_O: rom_en = 1'b1;
      S_HDR_D: rom_en = hdr_go;
      S_DAT_R: begin
        rom_en   = 1'b1;
        rom_addr = src_ptr;
      end
      default: rom_en = 1'b0;
    endcase
  end

  always_comb begin
    load      = send_st && !tx_busy;
    load_sel  = SEL_CTRL;
    load_word = {CTRL_ORDER, CTRL_ORDER};
    unique case (st)
      S_ADDR: begin
        load_sel  = SEL_ADDR;
        load_word = dest;
      end
      S_CFG_D: begin
        load_sel  = SEL_DFIX;
        load_word = word;
      end
      S_DAT_S: begin
        load_sel  = SEL_DINC;
        load_word = word;
      end
      S_WAKE: load_word = {CTRL_WAKE, CTRL_WAKE};
      default: load_sel = SEL_CTRL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      nxt      <= S_IDLE;
      tbl_ptr  <= '0;
      src_ptr  <= '0;
      dest     <= '0;
      word     <= '0;
      cnt      <= '0;
      cfg_left <= '0;
      sec_left <= '0;
      mode_sec <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rom_en && st != S_DAT_R) tbl_ptr <= tbl_ptr + 32'd1;
      unique case (st)
        S_IDLE: if (start) begin
          busy     <= 1'b1;
          tbl_ptr  <= '0;
          cfg_left <= CW'(CFG_N);
          sec_left <= SW'(MAX_SECT);
          st       <= (CFG_N == 0) ? S_HDR_D : S_CFG_A;
        end
        S_CFG_A: st <= S_CFG_V;
        S_CFG_V: begin
          dest <= rom_data;
          st   <= S_CFG_C;
        end
        S_CFG_C: begin
          word     <= rom_data;
          mode_sec <= 1'b0;
          st       <= S_CTRL;
        end
        S_HDR_D: st <= hdr_go ? S_HDR_N : S_WAKE;
        S_HDR_N: begin
          dest <= rom_data;
          st   <= S_HDR_O;
        end
        S_HDR_O: begin
          cnt <= rom_data;
          st  <= S_HDR_C;
        end
        S_HDR_C: begin
          src_ptr  <= rom_data;
          sec_left <= sec_left - SW'(1);
          mode_sec <= 1'b1;
          st       <= (cnt == '0) ? S_WAKE : S_CTRL;
        end
        S_CTRL: if (load) begin
          nxt <= S_ADDR;
          st  <= S_WAIT;
        end
        S_ADDR: if (load) begin
          nxt <= mode_sec ? S_DAT_R : S_CFG_D;
          st  <= S_WAIT;
        end
        S_CFG_D: if (load) begin
          cfg_left <= cfg_left - CW'(1);
          nxt      <= (cfg_left == CW'(1)) ? S_HDR_D : S_CFG_A;
          st       <= S_WAIT;
        end
        S_DAT_R: begin
          src_ptr <= src_ptr + 32'd1;
          st      <= S_DAT_C;
        end
        S_DAT_C: begin
          word <= rom_data;
          st   <= S_DAT_S;
        end
        S_DAT_S: if (load) begin
          cnt <= cnt - 32'd1;
          nxt <= (cnt == 32'd1) ? S_HDR_D : S_DAT_R;
          st  <= S_WAIT;
        end
        S_WAKE: if (load) begin
          nxt <= S_FIN;
          st  <= S_WAIT;
        end
        S_WAIT: if (pair_done) st <= nxt;
        S_FIN: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: done marks the end of a busy period
  p_done_busy_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

  // R7: a start seen mid-sequence does not end or restart it
  p_restart_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    busy && start && st != S_FIN |=> busy && st != S_IDLE);

  // R3: no section data is fetched while configuration entries remain
  p_cfg_first_r3: assert property (@(posedge clk) disable iff (rst)
    st == S_DAT_R |-> cfg_left == '0);

  // R1: ROM stays quiet outside a sequence
  p_rom_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rom_en);

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import bseq_pkg::*;
#(
  parameter int CFG_N    = 7,
  parameter int MAX_SECT = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        rom_en,
  output logic [31:0] rom_addr,
  input  logic [31:0] rom_data,
  output logic        prt_valid,
  input  logic        prt_ready,
  output logic [1:0]  prt_sel,
  output logic        prt_half,
  output logic [15:0] prt_data
);

  logic        load;
  logic [1:0]  load_sel;
  logic [31:0] load_word;
  logic        tx_busy;
  logic        pair_done;

  bseq_ctrl #(
    .CFG_N    (CFG_N),
    .MAX_SECT (MAX_SECT)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .rom_en    (rom_en),
    .rom_addr  (rom_addr),
    .rom_data  (rom_data),
    .load      (load),
    .load_sel  (load_sel),
    .load_word (load_word),
    .tx_busy   (tx_busy),
    .pair_done (pair_done)
  );

  bseq_half_tx u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_sel  (load_sel),
    .load_word (load_word),
    .tx_busy   (tx_busy),
    .pair_done (pair_done),
    .prt_valid (prt_valid),
    .prt_ready (prt_ready),
    .prt_sel   (prt_sel),
    .prt_half  (prt_half),
    .prt_data  (prt_data)
  );

  // R6: nothing is offered to the port outside a sequence
  p_idle_port_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !prt_valid);

endmodule

// File: tb/boot_seq_top_tb.sv
module boot_seq_top_tb;
  localparam int CFG_N    = 3;
  localparam int MAX_SECT = 4;
  localparam int HB       = 2 * CFG_N;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, start, busy, done, rom_en, prt_valid, prt_ready, prt_half;
  logic [31:0] rom_addr, rom_q;
  logic [1:0]  prt_sel;
  logic [15:0] prt_data;

  boot_seq_top #(.CFG_N(CFG_N), .MAX_SECT(MAX_SECT)) u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_q),
    .prt_valid(prt_valid), .prt_ready(prt_ready), .prt_sel(prt_sel),
    .prt_half(prt_half), .prt_data(prt_data)
  );

  logic [31:0] rom [0:127];
  always @(posedge clk) if (rom_en) rom_q <= rom[rom_addr[6:0]];

  int checks = 0, errors = 0;
  logic [18:0] got  [0:255];
  logic [18:0] expq [0:255];
  int n_got = 0, n_exp = 0, n_done = 0, rmode = 0, cyc = 0;

  // ready driver and stream recorder, both at the falling edge
  initial begin
    prt_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      case (rmode)
        0: prt_ready = 1'b1;
        1: prt_ready = cyc[0];
        default: prt_ready = (cyc % 3 == 0);
      endcase
      if (prt_valid && prt_ready) begin
        if (n_got < 256) got[n_got] = {prt_sel, prt_half, prt_data};
        n_got++;
      end
      if (done) n_done++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] cfg_addr(int i);  return 32'h0180_0000 + 32'(i) * 32'h4; endfunction
  function automatic logic [31:0] cfg_val(int i);   return 32'h5A3C_0F00 ^ (32'(i) * 32'h0101_1111); endfunction
  function automatic logic [31:0] sec_dest(int k);  return 32'h8000_0000 + 32'(k) * 32'h0001_0040; endfunction
  function automatic logic [31:0] sec_off(int k);   return 32'd40 + 32'(k) * 32'd8; endfunction
  function automatic logic [31:0] sec_word(int k, int j);
    return 32'hC0DE_0000 + (32'(k) << 12) + 32'(j) * 32'h0003_0101;
  endfunction

  task automatic fill_rom(input int ns);
    for (int a = 0; a < 128; a++) rom[a] = 32'hDEAD_0000 + 32'(a);
    for (int i = 0; i < CFG_N; i++) begin
      rom[2*i]   = cfg_addr(i);
      rom[2*i+1] = cfg_val(i);
    end
    for (int k = 0; k < MAX_SECT; k++) begin
      rom[HB+3*k]   = sec_dest(k);
      rom[HB+3*k+1] = (k < ns) ? 32'(k + 1) : ((k == ns) ? 32'd0 : 32'd5);
      rom[HB+3*k+2] = sec_off(k);
      for (int j = 0; j < 5; j++) rom[sec_off(k) + j] = sec_word(k, j);
    end
  endtask

  task automatic push_word(input logic [1:0] sel, input logic [31:0] w);
    expq[n_exp] = {sel, 1'b0, w[15:0]};  n_exp++;
    expq[n_exp] = {sel, 1'b1, w[31:16]}; n_exp++;
  endtask

  task automatic build_exp(input int ns);
    n_exp = 0;
    for (int i = 0; i < CFG_N; i++) begin
      push_word(2'b00, 32'h0001_0001);
      push_word(2'b01, cfg_addr(i));
      push_word(2'b11, cfg_val(i));
    end
    for (int k = 0; k < ns; k++) begin
      push_word(2'b00, 32'h0001_0001);
      push_word(2'b01, sec_dest(k));
      for (int j = 0; j <= k; j++) push_word(2'b10, sec_word(k, j));
    end
    push_word(2'b00, 32'h0002_0002);
  endtask

  task automatic run_case(input int ns, input int rm, input bit restart);
    int t;
    int bad [0:2];
    int first [0:2];
    fill_rom(ns);
    build_exp(ns);
    rmode = rm;
    @(negedge clk);
    n_got = 0; n_done = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6", "busy after start", busy, 1);
    if (restart) begin
      repeat (15) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (n_done == 0 && t < 4000) begin
      @(negedge clk);
      t++;
    end
    check(t < 4000, "R6", "done reached", t, 0);
    repeat (6) @(negedge clk);
    check(n_got == n_exp, "R4", "transfer count", n_got, n_exp);
    for (int r = 0; r < 3; r++) begin bad[r] = 0; first[r] = -1; end
    for (int i = 0; i < n_exp; i++) begin
      int r;
      r = (i < CFG_N * 6) ? 0 : ((i >= n_exp - 2) ? 2 : 1);
      if (i >= n_got || got[i] !== expq[i]) begin
        if (first[r] < 0) first[r] = i;
        bad[r]++;
      end
    end
    check(bad[0] == 0, "R3", "config stream",
          (first[0] >= 0 && first[0] < n_got) ? got[first[0]] : 0,
          (first[0] >= 0) ? expq[first[0]] : 0);
    check(bad[1] == 0, "R5/R2", "section stream",
          (first[1] >= 0 && first[1] < n_got) ? got[first[1]] : 0,
          (first[1] >= 0) ? expq[first[1]] : 0);
    check(bad[2] == 0, "R6", "wake pair",
          (first[2] >= 0 && first[2] < n_got) ? got[first[2]] : 0,
          (first[2] >= 0) ? expq[first[2]] : 0);
    check(n_done == 1, "R6", "done pulses", n_done, 1);
    check(busy == 1'b0 && prt_valid == 1'b0, "R6", "idle after done", {busy, prt_valid}, 0);
    if (ns == 0) check(n_got == CFG_N * 6 + 2, "R8", "empty table stream", n_got, CFG_N * 6 + 2);
    if (restart) check(n_done == 1 && n_got == n_exp, "R7", "start while busy ignored", n_got, n_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    start = 1'b0;
    repeat (4) @(negedge clk);
    check({busy, done, prt_valid, rom_en} == 4'b0, "R1", "state in reset",
          {busy, done, prt_valid, rom_en}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check({busy, done, prt_valid, rom_en} == 4'b0, "R1", "idle before start",
          {busy, done, prt_valid, rom_en}, 0);
    for (int ns = 0; ns <= MAX_SECT; ns++)
      for (int rm = 0; rm < 3; rm++)
        run_case(ns, rm, 1'b0);
    run_case(2, 2, 1'b1);
    run_case(MAX_SECT, 0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule